// File: doc/BRIEF.md
# PAUSE Frame Receive Decoder

This block sits beside a full-duplex Ethernet receive path and examines each incoming frame, one byte per strobe, for MAC control frames. When flow-control decoding is active and a well-formed PAUSE request arrives, the block loads a quantum counter with the requested pause time. It holds its transmitter-pause output high until that many quantum ticks have been counted. A quantum is 512 bit times, and an external tick input marks each one.

When a frame ends, the block issues a one-cycle status strobe with two flags. The control flag is set for every decoded control frame. The filter flag tells the receive application whether to keep the frame or flush it. A configuration bit selects whether control frames are handed on to the host or marked for flushing, but decoding and the control flag do not depend on that bit. Decoding happens only when flow control is enabled and the link runs full duplex. Otherwise frames pass through untouched and any active pause is dropped.

Top module: `pause_rx_decoder`

## Requirements
- R1: While fc_enable is 0, a frame ending produces ctrl_flag=0 and filter_flag=1, and tx_paused is 0 one cycle after fc_enable is seen low. This holds even for a valid PAUSE frame.
- R2: With fc_enable=1 and full_duplex=1, a valid PAUSE frame with a nonzero time sets tx_paused in the same cycle that its status strobe appears. The strobe appears two clock edges after the last byte is accepted.
- R3: A pause of N quanta stays asserted through N-1 quantum ticks and drops at the clock edge that takes the N-th tick.
- R4: Any frame whose bytes 12 and 13 carry the type 0x8808 is a control frame when decoding is active, and it sets ctrl_flag whatever its opcode and whatever pass_ctrl is.
- R5: For a decoded control frame, filter_flag equals pass_ctrl. For any other frame, filter_flag is 1.
- R6: While full_duplex is 0, no frame is decoded (ctrl_flag=0, filter_flag=1), and tx_paused is 0 one cycle after full_duplex is seen low.
- R7: A frame loads the pause timer only if all of the following hold. Bytes 0 to 5 are 01-80-C2-00-00-01. The type is 0x8808. Bytes 14 and 15 are the opcode 0x0001. The frame is at least 18 bytes long. rx_good is 1 with the last byte. Bytes 16 and 17 carry the pause time, most significant byte first.
- R8: A new valid PAUSE frame reloads the counter with its own value and discards the remainder. A value of 0 ends a pause at once.
- R9: Dropping fc_enable during a pause releases tx_paused on the next clock edge.
- R10: After reset, tx_paused, status_valid, ctrl_flag and filter_flag are all 0. status_valid is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Receive byte |
| rx_good | input | 1 | Frame integrity flag, sampled with the last byte |
| full_duplex | input | 1 | Link runs full duplex |
| fc_enable | input | 1 | Enables control-frame decoding and pausing |
| pass_ctrl | input | 1 | 1: hand control frames to the host; 0: mark them for flushing |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| tx_paused | output | 1 | Transmitter is held off |
| status_valid | output | 1 | One-cycle strobe marking the flags below as valid |
| ctrl_flag | output | 1 | Frame was a decoded control frame |
| filter_flag | output | 1 | 1: keep the frame; 0: flush it |

## Verification
Frames are sent under several patterns. A well-formed PAUSE request and an ordinary data frame show that the type check is what separates control frames from other traffic. A control frame with another opcode shows that the control flag and the timer load are separate decisions. Three near-miss PAUSE frames each break exactly one condition: a wrong destination, rx_good low, or a short length. A reload in mid-count, a zero-time request, and configuration changes during a pause check that the counter follows the latest request. Padded frames check that trailing bytes do not disturb the decoded fields.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;
  localparam int          BYTE_W        = 8;
  localparam int          TIME_W        = 16;
  localparam logic [47:0] PAUSE_DEST    = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_ETYPE    = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
  localparam int          DEST_BYTES    = 6;
  localparam int          OFS_ETYPE     = 12;
  localparam int          OFS_OPCODE    = 14;
  localparam int          OFS_TIME      = 16;
  localparam int          MIN_PAUSE_LEN = 18;

  typedef struct packed {
    logic dest_ok;
    logic etype_ok;
    logic hdr_seen;
    logic opcode_ok;
    logic len_ok;
    logic good;
  } frame_flags_t;
endpackage

// File: rtl/pause_rx_parser.sv
module pause_rx_parser
  import pause_rx_pkg::*;
#(
  parameter int IDX_MAX = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic [BYTE_W-1:0]   rx_data,
  input  logic                rx_good,
  output logic                frame_done,
  output frame_flags_t        flags,
  output logic [TIME_W-1:0]   pause_time
);
  localparam int IDX_W = $clog2(IDX_MAX + 1);

  logic [IDX_W-1:0]  idx_q, idx_cur;
  logic              dest_hit, etype_hit, opcode_hit;
  logic              done_q;
  frame_flags_t      flags_q;
  logic [TIME_W-1:0] time_q;

  function automatic logic word_hit(input logic [IDX_W-1:0] idx,
                                    input logic [BYTE_W-1:0] data,
                                    input logic [15:0] word, input int ofs);
    logic hit;
    hit = 1'b1;
    if (idx == IDX_W'(ofs))     hit = (data == word[15:8]);
    if (idx == IDX_W'(ofs + 1)) hit = (data == word[7:0]);
    return hit;
  endfunction

  assign idx_cur = rx_sof ? '0 : idx_q;

  always_comb begin
    dest_hit = 1'b1;
    for (int b = 0; b < DEST_BYTES; b++) begin
      if (idx_cur == IDX_W'(b))
        dest_hit = (rx_data == PAUSE_DEST[47-8*b -: 8]);
    end
    etype_hit  = word_hit(idx_cur, rx_data, CTRL_ETYPE, OFS_ETYPE);
    opcode_hit = word_hit(idx_cur, rx_data, PAUSE_OPCODE, OFS_OPCODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      done_q  <= 1'b0;
      flags_q <= '0;
      time_q  <= '0;
    end else begin
      done_q <= rx_valid & rx_eof;
      if (rx_valid) begin
        idx_q <= (idx_cur == IDX_W'(IDX_MAX)) ? idx_cur : idx_cur + 1'b1;
        flags_q.dest_ok   <= (rx_sof | flags_q.dest_ok)   & dest_hit;
        flags_q.etype_ok  <= (rx_sof | flags_q.etype_ok)  & etype_hit;
        flags_q.opcode_ok <= (rx_sof | flags_q.opcode_ok) & opcode_hit;
        flags_q.hdr_seen  <= (idx_cur >= IDX_W'(OFS_ETYPE + 1));
        flags_q.len_ok    <= (idx_cur >= IDX_W'(MIN_PAUSE_LEN - 1));
        flags_q.good      <= rx_good;
        if (idx_cur == IDX_W'(OFS_TIME))     time_q[15:8] <= rx_data;
        if (idx_cur == IDX_W'(OFS_TIME + 1)) time_q[7:0]  <= rx_data;
      end
    end
  end

  assign frame_done = done_q;
  assign flags      = flags_q;
  assign pause_time = time_q;
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
  import pause_rx_pkg::*;
#(
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                load,
  input  logic [TIME_W-1:0]   load_val,
  input  logic                tick,
  output logic                paused
);
  logic [QUANTA_W-1:0] cnt_q, cnt_n;
  logic                paused_q;

  always_comb begin
    cnt_n = cnt_q;
    if (!enable)
      cnt_n = '0;
    else if (load)
      cnt_n = QUANTA_W'(load_val);
    else if (tick && cnt_q != '0)
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      paused_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      paused_q <= (cnt_n != '0);
    end
  end

  assign paused = paused_q;
endmodule

// File: rtl/pause_rx_status.sv
module pause_rx_status (
  input  logic clk,
  input  logic rst,
  input  logic frame_done,
  input  logic decode_en,
  input  logic is_ctrl,
  input  logic pass_ctrl,
  output logic status_valid,
  output logic ctrl_flag,
  output logic filter_flag
);
  logic vld_q, ctrl_q, filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      ctrl_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      vld_q <= frame_done;
      if (frame_done) begin
        ctrl_q <= decode_en & is_ctrl;
        filt_q <= !(decode_en & is_ctrl & !pass_ctrl);
      end
    end
  end

  assign status_valid = vld_q;
  assign ctrl_flag    = ctrl_q;
  assign filter_flag  = filt_q;
endmodule

// File: rtl/pause_rx_decoder.sv
module pause_rx_decoder
  import pause_rx_pkg::*;
#(
  parameter int IDX_MAX  = 31,
  parameter int QUANTA_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic [7:0] rx_data,
  input  logic       rx_good,
  input  logic       full_duplex,
  input  logic       fc_enable,
  input  logic       pass_ctrl,
  input  logic       quanta_tick,
  output logic       tx_paused,
  output logic       status_valid,
  output logic       ctrl_flag,
  output logic       filter_flag
);
  frame_flags_t      flags;
  logic              frame_done, decode_en, is_ctrl, is_pause;
  logic [TIME_W-1:0] pause_time;

  pause_rx_parser #(.IDX_MAX(IDX_MAX)) u_parser (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_good(rx_good),
    .frame_done(frame_done), .flags(flags), .pause_time(pause_time)
  );

  assign decode_en = fc_enable & full_duplex;
  assign is_ctrl   = flags.etype_ok & flags.hdr_seen;
  assign is_pause  = is_ctrl & flags.dest_ok & flags.opcode_ok &
                     flags.len_ok & flags.good;

  pause_quanta_timer #(.QUANTA_W(QUANTA_W)) u_timer (
    .clk(clk), .rst(rst), .enable(decode_en),
    .load(frame_done & is_pause), .load_val(pause_time),
    .tick(quanta_tick), .paused(tx_paused)
  );

  pause_rx_status u_status (
    .clk(clk), .rst(rst), .frame_done(frame_done), .decode_en(decode_en),
    .is_ctrl(is_ctrl), .pass_ctrl(pass_ctrl), .status_valid(status_valid),
    .ctrl_flag(ctrl_flag), .filter_flag(filter_flag)
  );
endmodule

// File: rtl/pause_rx_decoder_chk.sv
module pause_rx_decoder_chk (
  input logic clk,
  input logic rst,
  input logic full_duplex,
  input logic fc_enable,
  input logic pass_ctrl,
  input logic quanta_tick,
  input logic tx_paused,
  input logic status_valid,
  input logic ctrl_flag,
  input logic filter_flag
);
  p_off_no_pause_r1: assert property (@(posedge clk) disable iff (rst)
    !fc_enable |=> !tx_paused);

  p_half_duplex_no_pause_r6: assert property (@(posedge clk) disable iff (rst)
    !full_duplex |=> !tx_paused);

  p_pause_starts_with_status_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_paused) |-> status_valid);

  p_release_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_paused) |-> ($past(quanta_tick) || status_valid ||
                          !$past(fc_enable) || !$past(full_duplex)));

  p_flush_needs_nopass_r5: assert property (@(posedge clk) disable iff (rst)
    (status_valid && ctrl_flag && !filter_flag) |-> !$past(pass_ctrl));

  p_plain_frame_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (status_valid && !ctrl_flag) |-> filter_flag);

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (rst)
    status_valid |=> !status_valid);
endmodule

bind pause_rx_decoder pause_rx_decoder_chk u_chk (
  .clk(clk), .rst(rst), .full_duplex(full_duplex), .fc_enable(fc_enable),
  .pass_ctrl(pass_ctrl), .quanta_tick(quanta_tick), .tx_paused(tx_paused),
  .status_valid(status_valid), .ctrl_flag(ctrl_flag), .filter_flag(filter_flag)
);

// File: tb/pause_rx_decoder_bench.sv
module pause_rx_decoder_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic [7:0] rx_data = '0;
  logic full_duplex = 1, fc_enable = 1, pass_ctrl = 0, quanta_tick = 0;
  logic tx_paused, status_valid, ctrl_flag, filter_flag;

  int tests = 0, fails = 0;
  bit finished = 0;

  typedef struct { bit c; bit f; bit p; string tag; } exp_t;
  exp_t exp_q[$];

  localparam logic [47:0] DA_OK  = 48'h0180_C200_0001;
  localparam logic [47:0] DA_BAD = 48'h0180_C200_0002;

  always #5 clk = ~clk;

  pause_rx_decoder u_pause_rx_decoder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_good(rx_good),
    .full_duplex(full_duplex), .fc_enable(fc_enable), .pass_ctrl(pass_ctrl),
    .quanta_tick(quanta_tick), .tx_paused(tx_paused),
    .status_valid(status_valid), .ctrl_flag(ctrl_flag), .filter_flag(filter_flag)
  );

  task automatic check(input bit act, input bit exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k, input logic [47:0] da,
      input logic [15:0] ty, input logic [15:0] op, input logic [15:0] pt);
    if (k < 6)   return da[47-8*k -: 8];
    if (k < 12)  return 8'h20 + 8'(k);
    if (k == 12) return ty[15:8];
    if (k == 13) return ty[7:0];
    if (k == 14) return op[15:8];
    if (k == 15) return op[7:0];
    if (k == 16) return pt[15:8];
    if (k == 17) return pt[7:0];
    return 8'(k);
  endfunction

  task automatic send(input logic [47:0] da, input logic [15:0] ty,
      input logic [15:0] op, input logic [15:0] pt, input int nb, input bit good,
      input bit ec, input bit ef, input bit ep, input string tag);
    exp_t e;
    e.c = ec; e.f = ef; e.p = ep; e.tag = tag;
    exp_q.push_back(e);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (k == 0); rx_eof = (k == nb - 1);
      rx_good = good; rx_data = fbyte(k, da, ty, op, pt);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      quanta_tick = 1;
    end
    @(negedge clk);
    quanta_tick = 0;
  endtask

  // monitor: pops one expected item per status strobe
  always @(negedge clk) begin
    if (!rst && status_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R10: unexpected status strobe, actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(ctrl_flag,   e.c, {e.tag, " ctrl_flag"});
        check(filter_flag, e.f, {e.tag, " filter_flag"});
        check(tx_paused,   e.p, {e.tag, " tx_paused"});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(tx_paused, 0, "R10 reset tx_paused");
    check(status_valid, 0, "R10 reset status_valid");
    check(ctrl_flag, 0, "R10 reset ctrl_flag");
    check(filter_flag, 0, "R10 reset filter_flag");

    // R2/R3: pause of 3 quanta, pass_ctrl=0
    send(DA_OK, 16'h8808, 16'h0001, 16'd3, 60, 1, 1, 0, 1, "R2 pause3");
    ticks(2);
    check(tx_paused, 1, "R3 after 2 of 3 ticks");
    ticks(1);
    check(tx_paused, 0, "R3 after 3 of 3 ticks");

    send(DA_OK, 16'h0800, 16'h0001, 16'd5, 60, 1, 0, 1, 0, "R5 data frame");
    send(DA_OK, 16'h8808, 16'h0002, 16'd5, 60, 1, 1, 0, 0, "R4 other opcode");

    pass_ctrl = 1;
    send(DA_BAD, 16'h8808, 16'h0001, 16'd5, 60, 1, 1, 1, 0, "R7 wrong dest");
    send(DA_OK, 16'h8808, 16'h0001, 16'd5, 60, 0, 1, 1, 0, "R7 bad frame");
    send(DA_OK, 16'h8808, 16'h0001, 16'd5, 16, 1, 1, 1, 0, "R7 short frame");

    // R8 reload
    send(DA_OK, 16'h8808, 16'h0001, 16'd10, 18, 1, 1, 1, 1, "R5 pass pause10");
    ticks(3);
    send(DA_OK, 16'h8808, 16'h0001, 16'd2, 60, 1, 1, 1, 1, "R8 reload2");
    ticks(1);
    check(tx_paused, 1, "R8 reload 1 of 2");
    ticks(1);
    check(tx_paused, 0, "R8 reload 2 of 2");

    send(DA_OK, 16'h8808, 16'h0001, 16'd50, 60, 1, 1, 1, 1, "R8 pause50");
    send(DA_OK, 16'h8808, 16'h0001, 16'd0, 60, 1, 1, 1, 0, "R8 zero time");

    // R9 fc drop mid pause
    send(DA_OK, 16'h8808, 16'h0001, 16'd100, 60, 1, 1, 1, 1, "R9 pause100");
    @(negedge clk); fc_enable = 0;
    @(negedge clk);
    check(tx_paused, 0, "R9 fc_enable dropped");
    send(DA_OK, 16'h8808, 16'h0001, 16'd100, 60, 1, 0, 1, 0, "R1 fc off");
    pass_ctrl = 0;
    send(DA_OK, 16'h8808, 16'h0001, 16'd100, 60, 1, 0, 1, 0, "R1 fc off nopass");
    fc_enable = 1;

    // R6 half duplex
    full_duplex = 0;
    send(DA_OK, 16'h8808, 16'h0001, 16'd100, 60, 1, 0, 1, 0, "R6 half duplex");
    full_duplex = 1;
    send(DA_OK, 16'h8808, 16'h0001, 16'd100, 60, 1, 1, 0, 1, "R6 pause full");
    @(negedge clk); full_duplex = 0;
    @(negedge clk);
    check(tx_paused, 0, "R6 duplex dropped");
    full_duplex = 1;

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, 1, "R10 all strobes seen");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule